// File: doc/BRIEF.md
# Two-Row Keypad Scanner with Boot Chord Detection

This block reads a six-key matrix wired as two rows of three columns and turns it into a boot decision. A start pulse begins a scan. The block selects the upper row on its single row-select output, waits a settle interval, and samples the three active-low column lines. It then selects the lower row, waits again, and samples the columns a second time. The six samples are packed into a pressed-key vector.

From that vector the block derives two flags. The recovery flag is raised when a fixed three-key chord is held. It is also raised when an external recovery-request input is high. The pause flag asks for a delayed boot. It is raised when at least one key is pressed and recovery is not requested. When both flags are low, the boot proceeds at once.

The controller has four states. IDLE waits for start. On start it goes to UPPER, which sets the row-select line low and loads the settle timer. When the timer expires, UPPER moves to LOWER: it captures the upper row, sets the row-select line high and reloads the timer. When the timer expires again, LOWER moves to REPORT and captures the lower row. REPORT publishes the vector and flags, pulses done, and returns to IDLE.

Top module: `kpd_chord_scanner`

## Requirements
- R1: While reset is held and after it is released, done, the key vector, both flags and the row-select output are all 0.
- R2: The upper row is scanned first, with row-select low; the lower row is scanned second, with row-select high. Row-select goes low on the edge that accepts start and goes high exactly SETTLE_CYC = CLK_HZ/1e6*SETTLE_US cycles later.
- R3: A column input at 0 means the key at that position is pressed. A column input at 1 means the key is released.
- R4: In the upper row, columns 0, 1 and 2 set vector bits 5, 3 and 4 respectively.
- R5: In the lower row, columns 0, 1 and 2 set vector bits 2, 1 and 0 respectively.
- R6: The recovery flag is 1 whenever vector bits 5, 3 and 0 are all 1, whatever the other bits hold.
- R7: If the external recovery input is high when the result is published, the recovery flag is 1 regardless of the keys.
- R8: The pause flag is 1 only when the vector is non-zero and the recovery flag is 0. It is never 1 at the same time as the recovery flag.
- R9: done is high for exactly one cycle, 2*SETTLE_CYC+1 cycles after the edge that accepted start. The vector and flags change only together with done and hold their values until the next done.
- R10: A start pulse that arrives while a scan is in progress is ignored. The scan keeps its timing and produces exactly one done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a scan |
| ext_recover_i | input | 1 | External request that forces recovery |
| col_n_i | input | 3 | Column inputs, active low |
| row_sel_o | output | 1 | Row select: 0 = upper row, 1 = lower row |
| done_o | output | 1 | One-cycle strobe when the result is published |
| keys_o | output | 6 | Pressed-key vector |
| recover_o | output | 1 | Recovery boot requested |
| pause_o | output | 1 | Paused boot requested |

## Verification
Two functions can decide the flags in the same publishing cycle: the key-chord detector and the external recovery request. The pause decision also depends on both of them. The bench sweeps all 64 key patterns twice, once with the external request low and once with it high. This makes chord detection, external forcing and the any-key pause meet in every combination. Each published flag pair is compared with a value the bench computes from the pattern and the external input, and the two flags must never be high together.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    localparam int unsigned NUM_ROWS = 2;
    localparam int unsigned NUM_COLS = 3;
    localparam int unsigned KEY_W    = NUM_ROWS * NUM_COLS;

    // vector bits that together form the recovery chord: 5, 3 and 0
    localparam logic [KEY_W-1:0] CHORD_MASK = 6'b101001;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UPPER  = 2'd1,
        ST_LOWER  = 2'd2,
        ST_REPORT = 2'd3
    } scan_state_t;

    // vector position of the key at (row, col)
    function automatic int unsigned key_pos(input int unsigned row, input int unsigned col);
        int unsigned pos;
        if (row == 0) begin
            case (col)
                0:       pos = 5;
                1:       pos = 3;
                default: pos = 4;
            endcase
        end else begin
            pos = 2 - col;
        end
        return pos;
    endfunction

endpackage

// File: rtl/kpd_settle_timer.sv
module kpd_settle_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/kpd_row_map.sv
module kpd_row_map
    import kpd_pkg::*;
#(
    parameter int unsigned ROW = 0
) (
    input  logic [NUM_COLS-1:0] col_n_i,
    output logic [KEY_W-1:0]    bits_o
);
    always_comb begin
        bits_o = '0;
        for (int unsigned c = 0; c < NUM_COLS; c++) begin
            bits_o[key_pos(ROW, c)] = !col_n_i[c];
        end
    end

endmodule

// File: rtl/kpd_boot_decide.sv
module kpd_boot_decide
    import kpd_pkg::*;
(
    input  logic [KEY_W-1:0] keys_i,
    input  logic             ext_i,
    output logic             recover_o,
    output logic             pause_o
);
    logic chord_held;

    assign chord_held = ((keys_i & CHORD_MASK) == CHORD_MASK);
    assign recover_o  = chord_held || ext_i;
    assign pause_o    = !recover_o && (keys_i != '0);

endmodule

// File: rtl/kpd_chord_scanner.sv
module kpd_chord_scanner
    import kpd_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SETTLE_US = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                ext_recover_i,
    input  logic [NUM_COLS-1:0] col_n_i,
    output logic                row_sel_o,
    output logic                done_o,
    output logic [KEY_W-1:0]    keys_o,
    output logic                recover_o,
    output logic                pause_o
);
    localparam int unsigned SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

    scan_state_t      state_q, state_d;
    logic             tmr_load, tmr_expired;
    logic [KEY_W-1:0] row_bits [NUM_ROWS];
    logic [KEY_W-1:0] acc_q;
    logic             dec_recover, dec_pause;

    kpd_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        kpd_row_map #(.ROW(r)) u_map (
            .col_n_i (col_n_i),
            .bits_o  (row_bits[r])
        );
    end

    kpd_boot_decide u_decide (
        .keys_i    (acc_q),
        .ext_i     (ext_recover_i),
        .recover_o (dec_recover),
        .pause_o   (dec_pause)
    );

    assign tmr_load = ((state_q == ST_IDLE) && start_i) ||
                      ((state_q == ST_UPPER) && tmr_expired);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)     state_d = ST_UPPER;
            ST_UPPER:  if (tmr_expired) state_d = ST_LOWER;
            ST_LOWER:  if (tmr_expired) state_d = ST_REPORT;
            ST_REPORT:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_sel_o <= 1'b0;
            acc_q     <= '0;
            keys_o    <= '0;
            recover_o <= 1'b0;
            pause_o   <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= (state_q == ST_REPORT);
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) row_sel_o <= 1'b0;
                end
                ST_UPPER: begin
                    if (tmr_expired) begin
                        acc_q     <= row_bits[0];
                        row_sel_o <= 1'b1;
                    end
                end
                ST_LOWER: begin
                    if (tmr_expired) acc_q <= acc_q | row_bits[1];
                end
                ST_REPORT: begin
                    keys_o    <= acc_q;
                    recover_o <= dec_recover;
                    pause_o   <= dec_pause;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/kpd_chord_checker.sv
module kpd_chord_checker
    import kpd_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SETTLE_US = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_recover_i,
    input logic             row_sel_o,
    input logic             done_o,
    input logic [KEY_W-1:0] keys_o,
    input logic             recover_o,
    input logic             pause_o
);
    localparam int unsigned SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic        row_prev_q;
    logic [31:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_prev_q <= 1'b0;
            stable_q   <= '0;
        end else begin
            row_prev_q <= row_sel_o;
            if (row_sel_o != row_prev_q)  stable_q <= '0;
            else if (stable_q != '1)      stable_q <= stable_q + 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(keys_o) && $stable(recover_o) && $stable(pause_o))); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(recover_o && pause_o)); // R8

    AST_ZERO_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && keys_o == '0) |-> !pause_o); // R8

    AST_CHORD_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ((keys_o & CHORD_MASK) == CHORD_MASK)) |-> recover_o); // R6

    AST_EXT_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(ext_recover_i)) |-> recover_o); // R7

    AST_LOWER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (row_sel_o && stable_q >= 32'(SETTLE_CYC - 1))); // R2

endmodule

bind kpd_chord_scanner kpd_chord_checker #(
    .CLK_HZ    (CLK_HZ),
    .SETTLE_US (SETTLE_US)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_recover_i (ext_recover_i),
    .row_sel_o     (row_sel_o),
    .done_o        (done_o),
    .keys_o        (keys_o),
    .recover_o     (recover_o),
    .pause_o       (pause_o)
);

// File: tb/sim_kpd_chord_scanner.sv
`timescale 1ns/1ps
module sim_kpd_chord_scanner;
    localparam int unsigned CLK_HZ    = 100_000_000;
    localparam int unsigned SETTLE_US = 1;
    localparam int S = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ext = 1'b0;
    logic [2:0] upper_n = 3'b111;
    logic [2:0] lower_n = 3'b111;
    logic [2:0] col_n;
    logic       row_sel, done, recover, pause;
    logic [5:0] keys;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // physical matrix model: columns follow the selected row
    assign col_n = row_sel ? lower_n : upper_n;

    kpd_chord_scanner #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ext_recover_i(ext),
        .col_n_i(col_n), .row_sel_o(row_sel), .done_o(done),
        .keys_o(keys), .recover_o(recover), .pause_o(pause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // place pattern k onto the physical matrix (R3 active low, R4/R5 positions)
    task automatic set_matrix(input int k);
        upper_n = ~{k[4], k[3], k[5]};
        lower_n = ~{k[0], k[1], k[2]};
    endtask

    // run one scan; optionally pulse start again mid-scan (R10)
    task automatic scan(input int k, input bit extra_start);
        int cnt;
        int dones;
        bit rec_e, pau_e;
        set_matrix(k);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cnt = 0;
        dones = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (extra_start && cnt == 5)   start = 1'b1;
            if (extra_start && cnt == 6)   start = 1'b0;
            if (cnt == S - 1) chk(row_sel == 1'b0, "R2 upper row first", row_sel, 0);
            if (cnt == S)     chk(row_sel == 1'b1, "R2 lower row second", row_sel, 1);
            if (done) break;
            if (cnt > 4 * S + 20) begin
                chk(1'b0, "R9 done never came", cnt, 2 * S + 1);
                return;
            end
        end
        chk(cnt == 2 * S + 1, "R9 done latency", cnt, 2 * S + 1);
        chk(keys == 6'(k), "R3 R4 R5 key vector", keys, k);
        rec_e = ext || (k[5] && k[3] && k[0]);
        pau_e = !rec_e && (k != 0);
        chk(recover == rec_e, ext ? "R7 ext recovery" : "R6 chord recovery", recover, rec_e);
        chk(pause == pau_e, "R8 pause flag", pause, pau_e);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        if (extra_start) begin
            for (int i = 0; i < 3 * S; i++) begin
                @(negedge clk);
                if (done) dones++;
            end
            chk(dones == 0, "R10 mid-scan start ignored", dones, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && keys == 0 && recover == 0 && pause == 0 && row_sel == 0,
            "R1 reset state", {row_sel, done, recover, pause}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && keys == 0 && recover == 0 && pause == 0 && row_sel == 0,
            "R1 after release", {row_sel, done, recover, pause}, 0);

        for (int e = 0; e < 2; e++) begin
            ext = e[0];
            for (int k = 0; k < 64; k++) scan(k, 1'b0);
        end

        // results hold while the matrix and external input change (R9)
        ext = 1'b0;
        scan(6'b101001, 1'b0);
        set_matrix(0);
        ext = 1'b1;
        repeat (3 * S) @(negedge clk);
        chk(keys == 6'b101001 && recover == 1 && pause == 0, "R9 hold until next done",
            keys, 6'b101001);

        ext = 1'b0;
        scan(6'b000100, 1'b1);
        scan(6'b101001, 1'b1);
        report();
    end

    initial begin
        repeat (150_000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

endmodule